// File: doc/BRIEF.md
# Six-Channel Linear Volume Scaler with Ramped Mute

This block sits in a multichannel audio playback path between the serial audio input and the interpolation filters. It receives six signed 24-bit samples together on one valid strobe and multiplies each by its own linear gain, one channel to each lane. It delivers the scaled samples two clock cycles later with a matching valid strobe. The gain scale has 1024 codes: code 1023 is unity and code 0 is silence, so one step is 1/1023 of full scale.

Gain and mute are held per channel in a small register set. A serial control port outside this block writes that register set through a one-cycle write strobe. The multiplier never sees the programmed value directly. It sees an effective gain that moves one code per accepted sample toward its target, so neither a gain change nor a mute causes a step in the output. The target is the programmed code while the channel is unmuted and zero while it is muted.

Top module: `chan_volume`

## Requirements
- R1: After reset every channel has effective gain 0, mute set and programmed code 0. `out_valid` is low and `out_data` is zero, and every sample gives a zero result until a channel is unmuted with a nonzero code.
- R2: `out_valid` is `in_valid` delayed by exactly two clock cycles. Back-to-back valid input cycles give back-to-back valid outputs.
- R3: Lane i of `out_data` (bits [24i+23:24i], two's complement) equals the lane i input sample times the channel's effective gain, divided by 1023 and truncated toward zero. The result is saturated to the 24-bit range. The effective gain used is the value held before this sample's ramp step.
- R4: On each clock with `in_valid` high, a channel's effective gain moves exactly one code toward its target, and it stays put once it equals the target. On clocks with `in_valid` low it does not change.
- R5: While a channel's mute bit is set, its target is 0 and its effective gain only falls. Clearing mute makes the target the programmed code again, and the gain climbs back one code per sample.
- R6: A write to channel c changes only channel c's code, mute and ramp. The other five channels keep their outputs.
- R7: A write with `cfg_ch` of 6 or 7 changes no channel.
- R8: A write that lands in the same cycle as a valid sample takes effect from the next sample. The coinciding sample is scaled and stepped with the old target.
- R9: At effective gain 1023 each output equals its input exactly, including the most negative value 0x800000 and the most positive value 0x7FFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | One-cycle write strobe for the register set |
| cfg_ch | input | 3 | Channel to write, 0 to 5 valid |
| cfg_gain | input | 10 | Linear gain code, 1023 is unity |
| cfg_mute | input | 1 | Mute bit for the written channel |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 144 | Six 24-bit two's complement samples, channel i in bits [24i+23:24i] |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 144 | Six scaled 24-bit samples, same layout as the input |

## Verification
A configuration write and a sample strobe can land on the same clock edge. That edge both advances the ramp and replaces the target the ramp steers by. The bench brings a channel to a steady gain and then issues a write for a higher code in the very cycle a sample arrives. All lanes are driven with the sample value 1023, so each output reads back the effective gain directly. The first two outputs must show the old gain unchanged, and only the third may show the first step toward the new code.

// File: rtl/chvol_pkg.sv
package chvol_pkg;

    localparam int DEF_NCH = 6;
    localparam int DEF_DW  = 24;
    localparam int DEF_GW  = 10;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;

endpackage

// File: rtl/chvol_regs.sv
module chvol_regs #(
    parameter int NCH = 6,
    parameter int GW  = 10,
    parameter int CHW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CHW-1:0]     cfg_ch,
    input  logic [GW-1:0]      cfg_gain,
    input  logic               cfg_mute,
    output logic [NCH*GW-1:0]  target_flat,
    output logic [NCH*GW-1:0]  gain_flat,
    output logic [NCH-1:0]     mute_vec
);

    typedef struct packed {
        logic [NCH-1:0][GW-1:0] gain;
        logic [NCH-1:0]         mute;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we && (32'(cfg_ch) < NCH)) begin
            regs_d.gain[cfg_ch] = cfg_gain;
            regs_d.mute[cfg_ch] = cfg_mute;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.gain <= '0;
            regs_q.mute <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_tgt
        assign gain_flat[i*GW +: GW]   = regs_q.gain[i];
        assign target_flat[i*GW +: GW] = regs_q.mute[i] ? '0 : regs_q.gain[i];
    end

    assign mute_vec = regs_q.mute;

endmodule

// File: rtl/chvol_ramp.sv
module chvol_ramp
    import chvol_pkg::*;
#(
    parameter int GW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic [GW-1:0] target,
    output logic [GW-1:0] eff
);

    ramp_dir_e     dir;
    logic [GW-1:0] eff_d, eff_q;

    always_comb begin
        if (target > eff_q) begin
            dir = RAMP_UP;
        end else if (target < eff_q) begin
            dir = RAMP_DOWN;
        end else begin
            dir = RAMP_HOLD;
        end

        eff_d = eff_q;
        if (step_en) begin
            case (dir)
                RAMP_UP:   eff_d = eff_q + GW'(1);
                RAMP_DOWN: eff_d = eff_q - GW'(1);
                default:   eff_d = eff_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eff_q <= '0;
        end else begin
            eff_q <= eff_d;
        end
    end

    assign eff = eff_q;

endmodule

// File: rtl/chvol_lane.sv
module chvol_lane #(
    parameter int DW = 24,
    parameter int GW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          out_en,
    input  logic [DW-1:0] smp,
    input  logic [GW-1:0] gain,
    output logic [DW-1:0] res
);

    localparam int    PW    = DW + GW + 1;
    localparam longint FULLV = (longint'(1) << GW) - 1;
    localparam longint POSV  = (longint'(1) << (DW - 1)) - 1;
    localparam longint NEGV  = -POSV - 1;
    localparam logic signed [PW-1:0] FULL    = PW'(FULLV);
    localparam logic signed [PW-1:0] POS_LIM = PW'(POSV);
    localparam logic signed [PW-1:0] NEG_LIM = PW'(NEGV);

    typedef struct packed {
        logic signed [PW-1:0] prod;
        logic        [DW-1:0] res;
    } lane_t;

    lane_t lane_d, lane_q;
    logic signed [PW-1:0] smp_x;
    logic signed [PW-1:0] gain_x;
    logic signed [PW-1:0] quot;

    always_comb begin
        lane_d = lane_q;
        smp_x  = $signed({{(GW + 1){smp[DW-1]}}, smp});
        gain_x = $signed({{(DW + 1){1'b0}}, gain});
        quot   = lane_q.prod / FULL;

        if (cap_en) begin
            lane_d.prod = smp_x * gain_x;
        end
        if (out_en) begin
            if (quot > POS_LIM) begin
                lane_d.res = POS_LIM[DW-1:0];
            end else if (quot < NEG_LIM) begin
                lane_d.res = NEG_LIM[DW-1:0];
            end else begin
                lane_d.res = quot[DW-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign res = lane_q.res;

endmodule

// File: rtl/chan_volume.sv
module chan_volume
    import chvol_pkg::*;
#(
    parameter int NCH = DEF_NCH,
    parameter int DW  = DEF_DW,
    parameter int GW  = DEF_GW,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic [GW-1:0]     cfg_gain,
    input  logic              cfg_mute,
    input  logic              in_valid,
    input  logic [NCH*DW-1:0] in_data,
    output logic              out_valid,
    output logic [NCH*DW-1:0] out_data
);

    typedef struct packed {
        logic v1;
        logic v2;
    } vld_t;

    vld_t vld_d, vld_q;
    logic                v1_q;
    logic [NCH*GW-1:0]   target_flat;
    logic [NCH*GW-1:0]   gain_flat;
    logic [NCH*GW-1:0]   eff_flat;
    logic [NCH-1:0]      mute_vec;

    chvol_regs #(
        .NCH (NCH),
        .GW  (GW),
        .CHW (CHW)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_ch      (cfg_ch),
        .cfg_gain    (cfg_gain),
        .cfg_mute    (cfg_mute),
        .target_flat (target_flat),
        .gain_flat   (gain_flat),
        .mute_vec    (mute_vec)
    );

    always_comb begin
        vld_d    = vld_q;
        vld_d.v1 = in_valid;
        vld_d.v2 = vld_q.v1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    assign v1_q      = vld_q.v1;
    assign out_valid = vld_q.v2;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        chvol_ramp #(
            .GW (GW)
        ) ramp_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_en (in_valid),
            .target  (target_flat[i*GW +: GW]),
            .eff     (eff_flat[i*GW +: GW])
        );

        chvol_lane #(
            .DW (DW),
            .GW (GW)
        ) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap_en (in_valid),
            .out_en (vld_q.v1),
            .smp    (in_data[i*DW +: DW]),
            .gain   (eff_flat[i*GW +: GW]),
            .res    (out_data[i*DW +: DW])
        );
    end

endmodule

// File: rtl/chvol_chk.sv
module chvol_chk #(
    parameter int NCH = 6,
    parameter int GW  = 10,
    parameter int CHW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              v1_q,
    input logic              out_valid,
    input logic              cfg_we,
    input logic [CHW-1:0]    cfg_ch,
    input logic [NCH*GW-1:0] eff_flat,
    input logic [NCH*GW-1:0] gain_flat,
    input logic [NCH-1:0]    mute_vec
);

    p_vld_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> v1_q);
    p_vld_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !v1_q);
    p_vld_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        v1_q |=> out_valid);
    p_vld_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !v1_q |=> !out_valid);

    // R7: an out-of-range channel write leaves every register unchanged
    p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (32'(cfg_ch) >= NCH)) |=> ($stable(gain_flat) && $stable(mute_vec)));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(eff_flat[i*GW +: GW]));
        p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> ((eff_flat[i*GW +: GW] == $past(eff_flat[i*GW +: GW]))
                       || (eff_flat[i*GW +: GW] == $past(eff_flat[i*GW +: GW]) + GW'(1))
                       || (eff_flat[i*GW +: GW] == $past(eff_flat[i*GW +: GW]) - GW'(1))));
        p_mute_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
            mute_vec[i] |=> (eff_flat[i*GW +: GW] <= $past(eff_flat[i*GW +: GW])));
    end

endmodule

bind chan_volume chvol_chk #(
    .NCH (NCH),
    .GW  (GW),
    .CHW (CHW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .v1_q      (v1_q),
    .out_valid (out_valid),
    .cfg_we    (cfg_we),
    .cfg_ch    (cfg_ch),
    .eff_flat  (eff_flat),
    .gain_flat (gain_flat),
    .mute_vec  (mute_vec)
);

// File: tb/chan_volume_tb_top.sv
`timescale 1ns/1ps
module chan_volume_tb_top;

    localparam int NCH = 6;
    localparam int DW  = 24;
    localparam int GW  = 10;
    localparam int CHW = 3;
    localparam int NV  = 8;

    // {gain code, lane 0 sample, lane 0 expected result}
    localparam logic [57:0] TBL [NV] = '{
        {10'd1023, 24'h7FFFFF, 24'h7FFFFF},
        {10'd1023, 24'h800000, 24'h800000},
        {10'd512,  24'h0F4240, 24'h07A308},
        {10'd512,  24'hF0BDC0, 24'hF85CF8},
        {10'd1,    24'h7FFFFF, 24'h002008},
        {10'd1,    24'hFFFC02, 24'h000000},
        {10'd0,    24'h01E240, 24'h000000},
        {10'd700,  24'hFFFFFB, 24'hFFFFFD}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CHW-1:0]    cfg_ch = '0;
    logic [GW-1:0]     cfg_gain = '0;
    logic              cfg_mute = 1'b0;
    logic              in_valid = 1'b0;
    logic [NCH*DW-1:0] in_data = '0;
    logic              out_valid;
    logic [NCH*DW-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    int eff_m  [NCH];
    int gain_m [NCH];
    bit mute_m [NCH];
    int smp_m  [NCH];

    always #2 clk = ~clk;

    chan_volume dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_gain  (cfg_gain),
        .cfg_mute  (cfg_mute),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    function automatic int tgt_of(input int c);
        return mute_m[c] ? 0 : gain_m[c];
    endfunction

    function automatic longint scale(input int s, input int e);
        longint p;
        p = (longint'(s) * longint'(e)) / 1023;
        if (p > 8388607) p = 8388607;
        if (p < -8388608) p = -8388608;
        return p;
    endfunction

    task automatic step_model();
        for (int c = 0; c < NCH; c++) begin
            if (eff_m[c] < tgt_of(c)) eff_m[c]++;
            else if (eff_m[c] > tgt_of(c)) eff_m[c]--;
        end
    endtask

    task automatic load_samples();
        for (int c = 0; c < NCH; c++) in_data[c*DW +: DW] = 24'(smp_m[c]);
    endtask

    task automatic do_write(input int ch, input int g, input bit m);
        cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_gain = GW'(g); cfg_mute = m;
        @(negedge clk);
        cfg_we = 1'b0;
        if (ch < NCH) begin gain_m[ch] = g; mute_m[ch] = m; end
    endtask

    // One sample, optionally with a coinciding write; checks latency and all lanes
    task automatic send_check(input string tag0, input string tagn,
                              input bit wr, input int wch, input int wg, input bit wm);
        longint exp [NCH];
        load_samples();
        in_valid = 1'b1;
        if (wr) begin
            cfg_we = 1'b1; cfg_ch = CHW'(wch); cfg_gain = GW'(wg); cfg_mute = wm;
        end
        for (int c = 0; c < NCH; c++) exp[c] = scale(smp_m[c], eff_m[c]);
        step_model();
        if (wr && wch < NCH) begin gain_m[wch] = wg; mute_m[wch] = wm; end
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b0;
        check("R2 one-cycle", longint'(out_valid), 0);
        @(negedge clk);
        check("R2 two-cycle", longint'(out_valid), 1);
        for (int c = 0; c < NCH; c++)
            check((c == 0) ? tag0 : tagn, longint'($signed(out_data[c*DW +: DW])), exp[c]);
    endtask

    task automatic pulse_n(input int n);
        load_samples();
        in_valid = 1'b1;
        for (int k = 0; k < n; k++) begin
            step_model();
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic all_smp(input int v);
        for (int c = 0; c < NCH; c++) smp_m[c] = v;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin eff_m[c] = 0; gain_m[c] = 0; mute_m[c] = 1'b1; end
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid", longint'(out_valid), 0);
        check("R1 out_data", longint'(out_data == '0), 1);

        all_smp(8388607);
        send_check("R1", "R1", 1'b0, 0, 0, 1'b0);
        do_write(0, 0, 1'b0);
        all_smp(1023);
        send_check("R1", "R1", 1'b0, 0, 0, 1'b0);

        // R2 streaming: three back-to-back samples
        all_smp(1);
        load_samples();
        in_valid = 1'b1;
        for (int n = 1; n <= 6; n++) begin
            if (n <= 3) step_model();
            @(negedge clk);
            if (n == 3) in_valid = 1'b0;
            check("R2 stream", longint'(out_valid), longint'(n >= 2 && n <= 4));
        end

        // R3 / R9 vector table
        for (int v = 0; v < NV; v++) begin
            for (int c = 0; c < NCH; c++) do_write(c, int'(TBL[v][57:48]), 1'b0);
            all_smp(0);
            pulse_n(1030);
            for (int c = 0; c < NCH; c++) smp_m[c] = int'($signed(TBL[v][47:24])) >>> c;
            send_check((TBL[v][57:48] == 10'd1023) ? "R9" : "R3", "R3", 1'b0, 0, 0, 1'b0);
            check("R3 table", longint'($signed(out_data[DW-1:0])), longint'($signed(TBL[v][23:0])));
        end

        // R4 single-code steps toward 703, then no step without valid
        for (int c = 0; c < NCH; c++) do_write(c, 703, 1'b0);
        all_smp(1023);
        for (int k = 0; k < 5; k++) begin
            send_check("R4", "R4", 1'b0, 0, 0, 1'b0);
            check("R4 step", longint'($signed(out_data[DW-1:0])), (700 + k > 703) ? 703 : 700 + k);
        end
        repeat (10) @(negedge clk);
        send_check("R4 idle", "R4 idle", 1'b0, 0, 0, 1'b0);

        // R5 mute ramps channel 0 down; R6 others untouched
        do_write(0, 703, 1'b1);
        send_check("R5", "R6", 1'b0, 0, 0, 1'b0);
        check("R5 first", longint'($signed(out_data[DW-1:0])), 703);
        pulse_n(710);
        send_check("R5", "R6", 1'b0, 0, 0, 1'b0);
        check("R5 floor", longint'($signed(out_data[DW-1:0])), 0);
        do_write(0, 703, 1'b0);
        for (int k = 0; k < 3; k++) begin
            send_check("R5", "R6", 1'b0, 0, 0, 1'b0);
            check("R5 rise", longint'($signed(out_data[DW-1:0])), k);
        end

        // R7 out-of-range channel writes
        do_write(6, 0, 1'b1);
        do_write(7, 0, 1'b1);
        send_check("R7", "R7", 1'b0, 0, 0, 1'b0);
        check("R7 ch1", longint'($signed(out_data[DW +: DW])), 703);

        // R8 write coinciding with a sample on channel 2 (steady at 703)
        send_check("R8", "R8", 1'b1, 2, 708, 1'b0);
        check("R8 first", longint'($signed(out_data[2*DW +: DW])), 703);
        send_check("R8", "R8", 1'b0, 0, 0, 1'b0);
        check("R8 second", longint'($signed(out_data[2*DW +: DW])), 703);
        send_check("R8", "R8", 1'b0, 0, 0, 1'b0);
        check("R8 third", longint'($signed(out_data[2*DW +: DW])), 704);

        summary();
    end

endmodule